// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word for one downstream port of a USB host controller root hub. Software reads and writes it through a plain single-cycle register interface. Hardware event lines from the port logic feed into it: connect detect, overcurrent detect, wake (J-to-K) detect, suspend state, reset completion with a high-speed flag, and end-of-frame fault disable. It drives the port enable, resume (K) signalling, and a one-cycle port-change request toward the controller's global status register.

The fields follow an asymmetric policy. Change flags are set by hardware and cleared when software writes 1 to them. When a set event and a clear land in the same cycle, the set wins. Software can disable the port but can never enable it. A resume raises the global change request only when hardware detected the wake. After software ends a resume, the resume bit keeps reading 1 for a fixed, parameterised settle time, which models the return to high-speed idle.

Each instance serves the port number given by a parameter. It answers at byte offset 0x64 + 4 × (port − 1) in the operational register space. There is no streaming data path, so all pins are plain level or strobe signals.

Top module: `rh_port_ctl`

## Requirements
- R1: After reset every field reads 0, and port_en, resume_drv and pcd_req are low.
- R2: Bit 0 reads the sampled connect input one cycle after it changes. Bit 1 is set on every change of that input and stays set through further changes. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R3: When a change-flag set event and a software write of 1 to that flag occur in the same cycle, the flag ends up set.
- R4: Bit 2 (port enabled, mirrored on port_en) is set only in the cycle after rst_done and rst_hs are both high. rst_done without rst_hs does not set it. Writing 1 to bit 2 has no effect. Writing 0 to bit 2 clears it without setting bit 3.
- R5: eof2_err while the port is enabled clears bit 2 and sets bit 3 (enable change). eof2_err while the port is disabled has no effect. Writing 1 to bit 3 clears it.
- R6: Bit 4 follows the sampled overcurrent input and returns to 0 when the input falls. Bit 5 is set on any change of that input and is cleared by writing 1 to it.
- R7: A jk_det pulse while port_suspended is high sets bit 6 and resume_drv in the next cycle, together with a single-cycle pcd_req pulse. jk_det while not suspended is ignored.
- R8: Software writing 1 to bit 6 sets bit 6 and resume_drv, and pcd_req stays low.
- R9: A write with bit 6 = 0 during a resume drops resume_drv at once. Bit 6 then keeps reading 1 for EXIT_CYCLES cycles and reads 0 afterwards.
- R10: While port_power is low, reg_rdata reads 0 at every field.
- R11: The register decodes only at byte address 0x64 + 4 × (PORT_NUM − 1). Writes to any other address change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| port_power | input | 1 | Port power on; when low, reads return 0 |
| conn_det | input | 1 | Device present on the port |
| ovc_det | input | 1 | Overcurrent condition present |
| jk_det | input | 1 | J-to-K wake transition seen |
| port_suspended | input | 1 | Port is in the suspend state |
| rst_done | input | 1 | Port reset sequence completed (strobe) |
| rst_hs | input | 1 | Device found high-speed at reset end |
| eof2_err | input | 1 | Fault disable at the end-of-frame check point |
| port_en | output | 1 | Port enabled |
| resume_drv | output | 1 | Drive resume K signalling |
| pcd_req | output | 1 | One-cycle global port-change request |

## Verification
A lost or phantom change flag shows at the next read as a wrong bit 1, 3 or 5, one cycle after the event. A set/clear priority fault shows only when the event and the write coincide, so that case is driven on purpose. A resume state machine stuck in the wrong state shows in two ways: resume_drv and bit 6 disagree, or bit 6 falls early or late relative to the exact EXIT_CYCLES window. A wrong wake source shows as a pcd_req pulse on a software-forced resume. An enable path that obeys software writes of 1 shows at port_en in the next cycle.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int B_CONN     = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_CHG   = 3;
  localparam int B_OC       = 4;
  localparam int B_OC_CHG   = 5;
  localparam int B_RESUME   = 6;
  localparam int FIELD_W    = 7;
  localparam int NUM_CHG    = 3;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRIVE = 2'd1,
    RS_EXIT  = 2'd2
  } rs_state_t;
endpackage

// File: rtl/rh_chg_flag.sv
module rh_chg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set dominates a same-cycle clear so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/rh_resume_ctl.sv
module rh_resume_ctl #(
  parameter int EXIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_wake_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic busy_o,
  output logic drive_o,
  output logic pcd_o
);
  import rh_port_pkg::*;

  localparam int CW = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(EXIT_CYCLES - 1);

  rs_state_t      state;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_IDLE;
      cnt   <= '0;
      pcd_o <= 1'b0;
    end else begin
      pcd_o <= 1'b0;
      unique case (state)
        RS_IDLE: begin
          if (hw_wake_i) begin
            state <= RS_DRIVE;
            pcd_o <= 1'b1;
          end else if (sw_set_i) begin
            state <= RS_DRIVE;
          end
        end
        RS_DRIVE: begin
          if (sw_clr_i) begin
            state <= RS_EXIT;
            cnt   <= LOAD;
          end
        end
        RS_EXIT: begin
          if (cnt == '0) state <= RS_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign busy_o  = (state != RS_IDLE);
  assign drive_o = (state == RS_DRIVE);
endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl #(
  parameter int PORT_NUM    = 1,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int EXIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              port_power,
  input  logic              conn_det,
  input  logic              ovc_det,
  input  logic              jk_det,
  input  logic              port_suspended,
  input  logic              rst_done,
  input  logic              rst_hs,
  input  logic              eof2_err,
  output logic              port_en,
  output logic              resume_drv,
  output logic              pcd_req
);
  import rh_port_pkg::*;

  localparam int BASE = 'h64 + 4 * (PORT_NUM - 1);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE);
  localparam int CHG_CONN = 0;
  localparam int CHG_EN   = 1;
  localparam int CHG_OC   = 2;
  localparam int CHG_BIT [NUM_CHG] = '{B_CONN_CHG, B_EN_CHG, B_OC_CHG};

  logic hit, wr;
  logic conn_q, oc_q;
  logic en_fault;
  logic res_busy;
  logic [NUM_CHG-1:0] chg_set, chg_clr, chg_q;
  logic [FIELD_W-1:0] stat;
  logic unused_wdata;

  assign hit = (reg_addr == MY_ADDR);
  assign wr  = reg_wr && hit;
  assign unused_wdata = ^reg_wdata[DATA_W-1:FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      conn_q <= conn_det;
      oc_q   <= ovc_det;
    end
  end

  assign en_fault = eof2_err && port_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      port_en <= 1'b0;
    else if (en_fault)               port_en <= 1'b0;
    else if (rst_done && rst_hs)     port_en <= 1'b1;
    else if (wr && !reg_wdata[B_EN]) port_en <= 1'b0;
  end

  assign chg_set[CHG_CONN] = conn_det ^ conn_q;
  assign chg_set[CHG_EN]   = en_fault;
  assign chg_set[CHG_OC]   = ovc_det ^ oc_q;

  for (genvar g = 0; g < NUM_CHG; g++) begin : g_chg
    assign chg_clr[g] = wr && reg_wdata[CHG_BIT[g]];
    rh_chg_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (chg_set[g]),
      .clr_i  (chg_clr[g]),
      .flag_o (chg_q[g])
    );
  end

  rh_resume_ctl #(.EXIT_CYCLES(EXIT_CYCLES)) u_resume (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_wake_i (jk_det && port_suspended),
    .sw_set_i  (wr && reg_wdata[B_RESUME]),
    .sw_clr_i  (wr && !reg_wdata[B_RESUME]),
    .busy_o    (res_busy),
    .drive_o   (resume_drv),
    .pcd_o     (pcd_req)
  );

  always_comb begin
    stat             = '0;
    stat[B_CONN]     = conn_q;
    stat[B_CONN_CHG] = chg_q[CHG_CONN];
    stat[B_EN]       = port_en;
    stat[B_EN_CHG]   = chg_q[CHG_EN];
    stat[B_OC]       = oc_q;
    stat[B_OC_CHG]   = chg_q[CHG_OC];
    stat[B_RESUME]   = res_busy;
  end

  assign reg_rdata = (hit && port_power) ? {{(DATA_W-FIELD_W){1'b0}}, stat} : '0;
endmodule

// File: rtl/rh_port_ctl_chk.sv
module rh_port_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic conn_lvl,
  input logic conn_chg,
  input logic oc_lvl,
  input logic oc_chg,
  input logic port_en,
  input logic en_chg,
  input logic eof2_err,
  input logic rst_done,
  input logic rst_hs,
  input logic jk_det,
  input logic port_suspended,
  input logic pcd_req,
  input logic resume_drv,
  input logic res_busy
);
  // R2
  conn_chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_lvl != $past(conn_lvl)) |-> conn_chg);

  // R6
  oc_chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lvl != $past(oc_lvl)) |-> oc_chg);

  // R4
  en_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_en) |-> $past(rst_done && rst_hs));

  // R5
  en_chg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_chg) |-> $past(eof2_err && port_en));

  // R7
  pcd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_req |-> $past(jk_det && port_suspended));

  // R7
  pcd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcd_req |=> !pcd_req);

  // R9
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resume_drv) |-> res_busy);
endmodule

bind rh_port_ctl rh_port_ctl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .conn_lvl       (conn_q),
  .conn_chg       (chg_q[0]),
  .oc_lvl         (oc_q),
  .oc_chg         (chg_q[2]),
  .port_en        (port_en),
  .en_chg         (chg_q[1]),
  .eof2_err       (eof2_err),
  .rst_done       (rst_done),
  .rst_hs         (rst_hs),
  .jk_det         (jk_det),
  .port_suspended (port_suspended),
  .pcd_req        (pcd_req),
  .resume_drv     (resume_drv),
  .res_busy       (res_busy)
);

// File: tb/rh_port_ctl_tb_top.sv
module rh_port_ctl_tb_top;
  localparam int CLK_P  = 10;
  localparam int PORT   = 2;
  localparam int NEXIT  = 8;
  localparam logic [7:0] MY_A    = 8'h68;
  localparam logic [7:0] OTHER_A = 8'h64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = MY_A;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        port_power = 1'b1;
  logic        conn_det = 1'b0, ovc_det = 1'b0, jk_det = 1'b0;
  logic        port_suspended = 1'b0, rst_done = 1'b0, rst_hs = 1'b0;
  logic        eof2_err = 1'b0;
  logic        port_en, resume_drv, pcd_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [34:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #(CLK_P/2) clk = ~clk;

  rh_port_ctl #(.PORT_NUM(PORT), .ADDR_W(8), .DATA_W(32), .EXIT_CYCLES(NEXIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_power(port_power),
    .conn_det(conn_det), .ovc_det(ovc_det), .jk_det(jk_det),
    .port_suspended(port_suspended), .rst_done(rst_done), .rst_hs(rst_hs),
    .eof2_err(eof2_err), .port_en(port_en), .resume_drv(resume_drv),
    .pcd_req(pcd_req)
  );

  // monitor: pops expected item and compares against the ports
  initial begin
    forever begin
      logic [34:0] obs, exp;
      string tag;
      @(mon_ev);
      obs = {pcd_req, resume_drv, port_en, reg_rdata};
      exp = exp_q.pop_front();
      tag = tag_q.pop_front();
      n_chk++;
      if (obs !== exp) begin
        n_err++;
        $display("FAIL %s: got pcd=%0b drv=%0b en=%0b rdata=%h, expected pcd=%0b drv=%0b en=%0b rdata=%h",
                 tag, obs[34], obs[33], obs[32], obs[31:0], exp[34], exp[33], exp[32], exp[31:0]);
      end
    end
  end

  task automatic chk(input logic [31:0] rd, input logic en, input logic drv,
                     input logic pcd, input string tag);
    exp_q.push_back({pcd, drv, en, rd});
    tag_q.push_back(tag);
    #1;
    -> mon_ev;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [31:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    step();
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic hs_reset();
    rst_done = 1'b1; rst_hs = 1'b1;
    step();
    rst_done = 1'b0; rst_hs = 1'b0;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'h0, 0, 0, 0, "R1 reset state");

    // R2 connect tracking and sticky change flag
    conn_det = 1'b1; step();
    chk(32'h3, 0, 0, 0, "R2 connect seen");
    conn_det = 1'b0; step();
    conn_det = 1'b1; step();
    chk(32'h3, 0, 0, 0, "R2 change stays set");
    wr_reg(32'h0);
    chk(32'h3, 0, 0, 0, "R2 write 0 keeps flag");
    wr_reg(32'h2);
    chk(32'h1, 0, 0, 0, "R2 write 1 clears flag");

    // R3 set beats clear
    reg_wr = 1'b1; reg_wdata = 32'h2; conn_det = 1'b0;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
    chk(32'h2, 0, 0, 0, "R3 set wins over clear");
    wr_reg(32'h2);
    chk(32'h0, 0, 0, 0, "R3 clear afterwards");

    // R4 enable policy
    wr_reg(32'h4);
    chk(32'h0, 0, 0, 0, "R4 software cannot enable");
    rst_done = 1'b1; rst_hs = 1'b0; step(); rst_done = 1'b0;
    chk(32'h0, 0, 0, 0, "R4 full-speed reset leaves disabled");
    hs_reset();
    chk(32'h4, 1, 0, 0, "R4 high-speed reset enables");
    wr_reg(32'h0);
    chk(32'h0, 0, 0, 0, "R4 software disable, no change flag");

    // R5 fault disable
    hs_reset();
    eof2_err = 1'b1; step(); eof2_err = 1'b0;
    chk(32'h8, 0, 0, 0, "R5 fault disables and flags");
    wr_reg(32'h8);
    chk(32'h0, 0, 0, 0, "R5 flag cleared");
    eof2_err = 1'b1; step(); eof2_err = 1'b0;
    chk(32'h0, 0, 0, 0, "R5 fault while disabled ignored");

    // R6 overcurrent
    ovc_det = 1'b1; step();
    chk(32'h30, 0, 0, 0, "R6 overcurrent active");
    ovc_det = 1'b0; step();
    chk(32'h20, 0, 0, 0, "R6 active returns to 0");
    wr_reg(32'h20);
    chk(32'h0, 0, 0, 0, "R6 change cleared");

    // R7 hardware wake
    jk_det = 1'b1; step(); jk_det = 1'b0;
    chk(32'h0, 0, 0, 0, "R7 wake ignored when not suspended");
    port_suspended = 1'b1;
    jk_det = 1'b1; step(); jk_det = 1'b0;
    chk(32'h40, 0, 1, 1, "R7 wake sets resume and pcd");
    step();
    chk(32'h40, 0, 1, 0, "R7 pcd single cycle");

    // R9 exit hold
    wr_reg(32'h0);
    chk(32'h40, 0, 0, 0, "R9 drive drops, bit still 1");
    repeat (NEXIT - 1) step();
    chk(32'h40, 0, 0, 0, "R9 bit held through last exit cycle");
    step();
    chk(32'h0, 0, 0, 0, "R9 bit clears after exit window");
    port_suspended = 1'b0;

    // R8 software resume
    wr_reg(32'h40);
    chk(32'h40, 0, 1, 0, "R8 software resume, no pcd");
    step();
    chk(32'h40, 0, 1, 0, "R8 pcd stays low");
    wr_reg(32'h0);
    repeat (NEXIT) step();
    chk(32'h0, 0, 0, 0, "R8 software resume ends");

    // R10 power off masking
    conn_det = 1'b1; step();
    chk(32'h3, 0, 0, 0, "R10 setup connect");
    port_power = 1'b0;
    chk(32'h0, 0, 0, 0, "R10 power off reads 0");
    port_power = 1'b1;
    chk(32'h3, 0, 0, 0, "R10 power on restores fields");

    // R11 address decode
    reg_addr = OTHER_A;
    chk(32'h0, 0, 0, 0, "R11 other address reads 0");
    wr_reg(32'h2);
    reg_addr = MY_A;
    chk(32'h3, 0, 0, 0, "R11 other address write ignored");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule